// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits beside the page-load path of a paged non-volatile memory and watches every accepted write. It recognises the short address/data command sequences that switch software write protection on and off. A three-byte prefix arms protection and also unlocks one load while protection is on. A six-byte sequence that starts like the prefix clears protection. Every byte that belongs to a command is flagged so the page latch drops it. The protection state itself changes only when the programming period that follows the command ends.

For each accepted write, the block reports whether that byte may be committed to the array. Writes made while protected without the prefix are refused: the surrounding logic still runs its program timer, but nothing is stored. A load-window timeout abandons any sequence that is only partly matched. Only the 15 low address bits take part in matching, so the port carries just those.

Top module: `wp_seq_detect`

## Requirements
- R1: After reset `protected_o` is 0, and `commit_ok` and `cmd_byte` are 0 whenever `wr_valid` is 0.
- R2: The writes 0xAA to 0x5555, 0x55 to 0x2AAA and 0xA0 to 0x5555, in that order, set `protected_o` to 1 on the clock edge that samples the next `prog_done`, and not earlier.
- R3: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA and 0x20@0x5555 clear `protected_o` on the clock edge that samples the next `prog_done`. Writes loaded after this sequence in the same window are committed.
- R4: A write that matches the next expected command byte has `cmd_byte`=1 and `commit_ok`=0 in its own cycle.
- R5: A write that does not match the next expected byte returns the matcher to idle. That write has `cmd_byte`=0 and is handled as ordinary data under the current protection state.
- R6: While protected, a write that is not preceded by a completed prefix has `commit_ok`=0 and `cmd_byte`=0.
- R7: While protected, writes that follow a completed prefix have `commit_ok`=1, and `protected_o` stays 1 after the next `prog_done`.
- R8: `load_timeout` during a partly matched sequence abandons it, so the remaining bytes of that sequence become ordinary data.
- R9: `protected_o` changes only on a cycle that samples `prog_done`. A `prog_done` or `load_timeout` without a completed sequence leaves it unchanged.
- R10: While unprotected, a write that is not a command byte has `commit_ok`=1.
- R11: The state change from a completed sequence takes effect at `prog_done` even when no data byte follows the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | An accepted write is present this cycle |
| wr_addr | input | 15 | Low address bits of the write |
| wr_data | input | 8 | Data byte of the write |
| load_timeout | input | 1 | The byte-load window has expired |
| prog_done | input | 1 | The programming period has ended |
| protected_o | output | 1 | Software write protection is active |
| commit_ok | output | 1 | This write's byte may be stored |
| cmd_byte | output | 1 | This write is a command byte and must not be stored |

## Verification
The bench drives several kinds of stimulus, each aimed at a different fault:
- **Directed sequences.** Enable, disable and unlock sequences are sent both clean and broken: with a wrong byte, with a timeout in the middle, and with nothing following. These separate correct step tracking and edge-only state change from early or stuck state change.
- **Random streams.** These are weighted toward the two command addresses and the command data values, and sometimes inject a whole sequence. They exercise near-miss prefixes and mid-sequence timeouts, which catch wrong reset-to-idle handling.
- **Random `prog_done` and timeout pulses.** Pulses placed between writes show whether a pending change is applied once and cleared afterwards.

// File: rtl/wp_seq_detect.sv
module wp_seq_detect #(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter logic [AW-1:0] ADDR_A = 15'h5555,
  parameter logic [AW-1:0] ADDR_B = 15'h2AAA,
  parameter logic [DW-1:0] K_FIRST = 8'hAA,
  parameter logic [DW-1:0] K_SECOND = 8'h55,
  parameter logic [DW-1:0] K_ARM = 8'hA0,
  parameter logic [DW-1:0] K_ESC = 8'h80,
  parameter logic [DW-1:0] K_CLEAR = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          load_timeout,
  input  logic          prog_done,
  output logic          protected_o,
  output logic          commit_ok,
  output logic          cmd_byte
);

  typedef enum logic [2:0] {
    S_IDLE, S_P1, S_P2, S_D3, S_D4, S_D5, S_OPEN
  } st_t;

  st_t  st, st_nx;
  logic prot_q, arm_q, clr_q;
  logic hit, set_arm, set_clr;

  wire at_a = (wr_addr == ADDR_A);
  wire at_b = (wr_addr == ADDR_B);

  always_comb begin
    st_nx   = st;
    hit     = 1'b0;
    set_arm = 1'b0;
    set_clr = 1'b0;
    case (st)
      S_IDLE: if (at_a && wr_data == K_FIRST)  begin hit = 1'b1; st_nx = S_P1; end
      S_P1:   if (at_b && wr_data == K_SECOND) begin hit = 1'b1; st_nx = S_P2; end
      S_P2: begin
        if (at_a && wr_data == K_ARM) begin
          hit = 1'b1; st_nx = S_OPEN; set_arm = 1'b1;
        end else if (at_a && wr_data == K_ESC) begin
          hit = 1'b1; st_nx = S_D3;
        end
      end
      S_D3:   if (at_a && wr_data == K_FIRST)  begin hit = 1'b1; st_nx = S_D4; end
      S_D4:   if (at_b && wr_data == K_SECOND) begin hit = 1'b1; st_nx = S_D5; end
      S_D5: begin
        if (at_a && wr_data == K_CLEAR) begin
          hit = 1'b1; st_nx = S_OPEN; set_clr = 1'b1;
        end
      end
      default: ;
    endcase
    if (!hit && st != S_OPEN) st_nx = S_IDLE;
  end

  assign cmd_byte    = wr_valid & hit;
  assign commit_ok   = wr_valid & ~hit & (~prot_q | (st == S_OPEN));
  assign protected_o = prot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      prot_q <= 1'b0;
      arm_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else if (prog_done) begin
      if (arm_q)      prot_q <= 1'b1;
      else if (clr_q) prot_q <= 1'b0;
      arm_q <= 1'b0;
      clr_q <= 1'b0;
      st    <= S_IDLE;
    end else if (load_timeout) begin
      if (st != S_OPEN) st <= S_IDLE;
    end else if (wr_valid) begin
      st <= st_nx;
      if (set_arm) arm_q <= 1'b1;
      if (set_clr) clr_q <= 1'b1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> (!commit_ok && !cmd_byte));

  // R4
  cmd_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_byte && commit_ok));

  // R9
  prot_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(protected_o) |-> $past(prog_done));

  // R8
  timeout_abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_timeout && !prog_done && st != S_OPEN) |=> (st == S_IDLE));

  // R6
  locked_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (protected_o && commit_ok) |-> (st == S_OPEN));

  // R9
  no_pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done && !arm_q && !clr_q) |=> $stable(protected_o));

endmodule

// File: tb/wp_seq_detect_tb.sv
module wp_seq_detect_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, load_timeout = 0, prog_done = 0;
  logic [14:0] wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic protected_o, commit_ok, cmd_byte;

  int n_chk = 0, n_fail = 0;
  int m_st = 0;
  bit m_prot = 0, m_arm = 0, m_clr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wp_seq_detect dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_timeout(load_timeout), .prog_done(prog_done),
    .protected_o(protected_o), .commit_ok(commit_ok), .cmd_byte(cmd_byte));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int next_of(int st, logic [14:0] a, logic [7:0] d);
    case (st)
      0: return (a == 15'h5555 && d == 8'hAA) ? 1 : -1;
      1: return (a == 15'h2AAA && d == 8'h55) ? 2 : -1;
      2: if (a == 15'h5555 && d == 8'hA0) return 6;
         else if (a == 15'h5555 && d == 8'h80) return 3;
         else return -1;
      3: return (a == 15'h5555 && d == 8'hAA) ? 4 : -1;
      4: return (a == 15'h2AAA && d == 8'h55) ? 5 : -1;
      5: return (a == 15'h5555 && d == 8'h20) ? 7 : -1;
      default: return -2;
    endcase
  endfunction

  task automatic step(input bit v, input logic [14:0] a, input logic [7:0] d,
                      input bit to, input bit pd, input string req);
    int nx;
    bit e_cmd, e_com;
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d; load_timeout = to; prog_done = pd;
    #1;
    nx    = next_of(m_st, a, d);
    e_cmd = v && (nx >= 0);
    e_com = v && !e_cmd && (!m_prot || m_st == 6);
    check({req, " cmd_byte"}, cmd_byte, e_cmd);
    check({req, " commit_ok"}, commit_ok, e_com);
    if (pd) begin
      if (m_arm) m_prot = 1; else if (m_clr) m_prot = 0;
      m_arm = 0; m_clr = 0; m_st = 0;
    end else if (to) begin
      if (m_st != 6) m_st = 0;
    end else if (v) begin
      if (nx == 7) begin m_clr = 1; m_st = 6; end
      else if (nx == 6) begin m_arm = 1; m_st = 6; end
      else if (nx >= 0) m_st = nx;
      else if (m_st != 6) m_st = 0;
    end
    @(posedge clk); #1;
    check({req, " protected_o"}, protected_o, m_prot);
    wr_valid = 0; load_timeout = 0; prog_done = 0;
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input string req);
    step(1, a, d, 0, 0, req);
  endtask

  task automatic prefix(input string req);
    wr(15'h5555, 8'hAA, req); wr(15'h2AAA, 8'h55, req); wr(15'h5555, 8'hA0, req);
  endtask

  task automatic disable_seq(input string req);
    wr(15'h5555, 8'hAA, req); wr(15'h2AAA, 8'h55, req); wr(15'h5555, 8'h80, req);
    wr(15'h5555, 8'hAA, req); wr(15'h2AAA, 8'h55, req); wr(15'h5555, 8'h20, req);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    #1;
    check("R1 reset protected_o", protected_o, 1'b0);
    check("R1 reset commit_ok", commit_ok, 1'b0);
    check("R1 reset cmd_byte", cmd_byte, 1'b0);
    @(negedge clk); rst_n = 1;

    wr(15'h0123, 8'h3C, "R10 plain write unprotected");
    prefix("R2 R4 enable prefix");
    step(0, 0, 0, 0, 0, "R2 no change before prog_done");
    step(0, 0, 0, 1, 0, "R11 timeout after command");
    step(0, 0, 0, 0, 1, "R2 R11 protect set at prog_done");
    wr(15'h0040, 8'h11, "R6 protected unprefixed write");
    step(0, 0, 0, 0, 1, "R9 prog_done with nothing pending");
    prefix("R7 unlock prefix");
    wr(15'h0200, 8'h77, "R7 unlocked data");
    wr(15'h0201, 8'h78, "R7 unlocked data 2");
    step(0, 0, 0, 0, 1, "R7 still protected");
    wr(15'h5555, 8'hAA, "R8 partial");
    wr(15'h2AAA, 8'h55, "R8 partial");
    step(0, 0, 0, 1, 0, "R8 timeout mid sequence");
    wr(15'h5555, 8'hA0, "R8 leftover byte is data");
    wr(15'h5555, 8'hAA, "R5 start");
    wr(15'h2AAA, 8'h56, "R5 wrong byte");
    wr(15'h5555, 8'hA0, "R5 back to idle");
    step(0, 0, 0, 0, 1, "R9 no change");
    disable_seq("R3 R4 disable sequence");
    wr(15'h0300, 8'h5A, "R3 data after disable");
    step(0, 0, 0, 0, 1, "R3 protect cleared");
    wr(15'h0301, 8'h5B, "R10 unprotected again");

    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 39);
      if (r == 0) prefix("R2 R7 random prefix");
      else if (r == 1) disable_seq("R3 random disable");
      else if (r < 4) step(0, 0, 0, 0, 1, "R9 random prog_done");
      else if (r < 6) step(0, 0, 0, 1, 0, "R8 random timeout");
      else begin
        logic [14:0] a;
        logic [7:0] d;
        int ra = $urandom_range(0, 3);
        int rd = $urandom_range(0, 6);
        a = (ra == 0) ? 15'h5555 : (ra == 1) ? 15'h2AAA : 15'($urandom);
        case (rd)
          0: d = 8'hAA; 1: d = 8'h55; 2: d = 8'hA0; 3: d = 8'h80; 4: d = 8'h20;
          default: d = 8'($urandom);
        endcase
        wr(a, d, "R5 R6 R10 random write");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule